// File: doc/BRIEF.md
# Debug Event Qualifier

This block sits behind the address comparators of a debug unit. It holds a bank of instruction breakpoint slots and a bank of data watchpoint slots. Each slot has a control word and a value word. A comparator reports a raw per-slot hit. The block decides whether that hit counts as a debug event for the processor's current state. The checks cover the processor's security state, its privilege level, an optional link to a context-ID comparator, and the global debug enables. The result is one breakpoint match flag and one watchpoint match flag, each registered for one cycle.

The slot registers are loaded through a plain address/data write port. A watchpoint hit raised by an unprivileged load/store is judged as if the processor were at level 0. The security filter uses only the processor's security state. Linked context matching borrows a breakpoint slot from a window of context-aware slots at the top of the breakpoint bank.

Top module: `dbgm_matcher`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at the next clock edge into slot `wr_idx` of the register chosen by `wr_sel`: 0 = breakpoint control, 1 = breakpoint value, 2 = watchpoint control, 3 = watchpoint value. The new contents govern matching from the following cycle. Reset clears every register, so no slot matches after reset.
- R2: `bp_match` (`wp_match`) is high one clock after a cycle in which at least one breakpoint (watchpoint) slot with its raw hit set passes every filter. It is the OR over all slots and is low when no hit is present.
- R3: A slot takes part only when bit 0 of its control word is 1.
- R4: Control bits 15:14 select the security filter. Value 0 accepts either state, 2 accepts only secure state, and 1 or 3 accept only non-secure state. The state used is `sec_state` (1 = secure).
- R5: At level 2 or 3 a slot passes only when control bit 13 is set. At level 1 it passes only when bit 1 is set. At level 0 it passes only when bit 2 is set.
- R6: When `wp_unpriv` is high, watchpoint slots apply the level rule for level 0 whatever `cur_el` holds. Breakpoint slots ignore `wp_unpriv`.
- R7: When control bit 20 is set, the slot also requires its link to fire. The link target is breakpoint slot number control bits 19:16. The link fails unless that number lies in [N-CTX_N, N-1].
- R8: A link target fires only when four conditions hold. Its control bit 0 is set. Its control bits 23:20 equal 3. Its 32-bit value equals `ctx_id`. `cur_el` is 0 or 1. Any other type never fires.
- R9: Both outputs are held low one clock after any cycle in which `mon_en` or `dbg_allow` is low.
- R10: While `rst` is high and on the cycle after it, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R1) |
| wr_idx | input | IW | Slot index of the write |
| wr_data | input | 32 | Write data |
| bp_hit | input | N | Raw breakpoint comparator hits, one per slot |
| wp_hit | input | N | Raw watchpoint comparator hits, one per slot |
| cur_el | input | 2 | Current privilege level 0..3 |
| sec_state | input | 1 | 1 = processor in secure state |
| wp_unpriv | input | 1 | Data access comes from an unprivileged load/store |
| ctx_id | input | 32 | Current context identifier |
| mon_en | input | 1 | Global debug-monitor enable |
| dbg_allow | input | 1 | Debug exceptions currently permitted |
| bp_match | output | 1 | Registered breakpoint event |
| wp_match | output | 1 | Registered watchpoint event |

## Verification
A qualified hit appears on `bp_match` or `wp_match` exactly one clock edge after the inputs that caused it are applied. A register write takes effect for hits presented from the cycle after its edge. The driver applies each stimulus at a falling edge and queues the expected pair of flags. The monitor pops one entry at the next rising edge and compares shortly after it, so each expectation meets the result of the edge that registered it. Configuration writes are issued in cycles that queue nothing.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  typedef logic [31:0] word_t;

  localparam int EN_BIT    = 0;
  localparam int EL1_BIT   = 1;
  localparam int EL0_BIT   = 2;
  localparam int HI_BIT    = 13;
  localparam int SEC_LO    = 14;
  localparam int LNK_LO    = 16;
  localparam int LNK_BIT   = 20;
  localparam int TYPE_LO   = 20;
  localparam logic [3:0] TYPE_CTX = 4'd3;

  function automatic logic level_ok(input word_t c, input logic [1:0] el);
    case (el)
      2'd0:    level_ok = c[EL0_BIT];
      2'd1:    level_ok = c[EL1_BIT];
      default: level_ok = c[HI_BIT];
    endcase
  endfunction

  function automatic logic world_ok(input word_t c, input logic sec);
    case (c[SEC_LO+1:SEC_LO])
      2'd0:    world_ok = 1'b1;
      2'd2:    world_ok = sec;
      default: world_ok = !sec;
    endcase
  endfunction
endpackage

// File: rtl/dbgm_regfile.sv
module dbgm_regfile #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [IW-1:0]        wr_idx,
  input  dbgm_pkg::word_t      wr_data,
  output dbgm_pkg::word_t      bp_ctrl [N],
  output dbgm_pkg::word_t      bp_val  [N],
  output dbgm_pkg::word_t      wp_ctrl [N],
  output dbgm_pkg::word_t      wp_val  [N]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        bp_ctrl[i] <= '0;
        bp_val[i]  <= '0;
        wp_ctrl[i] <= '0;
        wp_val[i]  <= '0;
      end
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: bp_ctrl[wr_idx] <= wr_data;
        2'd1: bp_val[wr_idx]  <= wr_data;
        2'd2: wp_ctrl[wr_idx] <= wr_data;
        default: wp_val[wr_idx] <= wr_data;
      endcase
    end
  end
endmodule

// File: rtl/dbgm_ctx_linker.sv
module dbgm_ctx_linker #(
  parameter int N     = 16,
  parameter int CTX_N = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  dbgm_pkg::word_t bp_ctrl [N],
  input  dbgm_pkg::word_t bp_val  [N],
  input  dbgm_pkg::word_t ctx_id,
  input  logic [1:0]      el,
  output logic [N-1:0]    fire
);
  import dbgm_pkg::*;
  localparam int LO = N - CTX_N;

  for (genvar j = 0; j < N; j++) begin : g_slot
    if (j >= LO) begin : g_ctx
      assign fire[j] = bp_ctrl[j][EN_BIT]
                    && (bp_ctrl[j][TYPE_LO+3:TYPE_LO] == TYPE_CTX)
                    && (bp_val[j] == ctx_id)
                    && (el <= 2'd1);
    end else begin : g_plain
      assign fire[j] = 1'b0;
    end
  end

  // R8
  link_el_chk: assert property (@(posedge clk) disable iff (rst)
    (fire != '0) |-> (el <= 2'd1));
endmodule

// File: rtl/dbgm_slot_filter.sv
module dbgm_slot_filter #(
  parameter int N = 16
) (
  input  dbgm_pkg::word_t ctrl [N],
  input  logic [N-1:0]    hit,
  input  logic [1:0]      el,
  input  logic            sec,
  input  logic [N-1:0]    link_fire,
  output logic            any
);
  import dbgm_pkg::*;
  localparam int PW = (N > 16) ? N : 16;

  logic [PW-1:0] fire_pad;
  logic [N-1:0]  pass;

  assign fire_pad = PW'(link_fire);

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [3:0] tgt;
    logic       link_ok;
    assign tgt     = ctrl[i][LNK_LO+3:LNK_LO];
    assign link_ok = !ctrl[i][LNK_BIT] || fire_pad[tgt];
    assign pass[i] = hit[i] && ctrl[i][EN_BIT] && level_ok(ctrl[i], el)
                  && world_ok(ctrl[i], sec) && link_ok;
  end

  assign any = |pass;
endmodule

// File: rtl/dbgm_matcher.sv
module dbgm_matcher #(
  parameter int N     = 16,
  parameter int CTX_N = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [N-1:0]  bp_hit,
  input  logic [N-1:0]  wp_hit,
  input  logic [1:0]    cur_el,
  input  logic          sec_state,
  input  logic          wp_unpriv,
  input  logic [31:0]   ctx_id,
  input  logic          mon_en,
  input  logic          dbg_allow,
  output logic          bp_match,
  output logic          wp_match
);
  import dbgm_pkg::*;

  word_t bp_ctrl [N];
  word_t bp_val  [N];
  word_t wp_ctrl [N];
  word_t wp_val  [N];
  logic [N-1:0] fire;
  logic [1:0]   wp_el;
  logic         bp_any, wp_any, gate;

  dbgm_regfile #(.N(N), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .bp_ctrl(bp_ctrl), .bp_val(bp_val),
    .wp_ctrl(wp_ctrl), .wp_val(wp_val)
  );

  dbgm_ctx_linker #(.N(N), .CTX_N(CTX_N)) u_link (
    .clk(clk), .rst(rst), .bp_ctrl(bp_ctrl), .bp_val(bp_val),
    .ctx_id(ctx_id), .el(cur_el), .fire(fire)
  );

  assign wp_el = wp_unpriv ? 2'd0 : cur_el;

  dbgm_slot_filter #(.N(N)) u_bp (
    .ctrl(bp_ctrl), .hit(bp_hit), .el(cur_el), .sec(sec_state),
    .link_fire(fire), .any(bp_any)
  );

  dbgm_slot_filter #(.N(N)) u_wp (
    .ctrl(wp_ctrl), .hit(wp_hit), .el(wp_el), .sec(sec_state),
    .link_fire(fire), .any(wp_any)
  );

  assign gate = mon_en && dbg_allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_match <= 1'b0;
      wp_match <= 1'b0;
    end else begin
      bp_match <= gate && bp_any;
      wp_match <= gate && wp_any;
    end
  end

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_en || !dbg_allow) |=> (!bp_match && !wp_match));
  // R2
  bp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_hit == '0) |=> !bp_match);
  // R2
  wp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wp_hit == '0) |=> !wp_match);
endmodule

// File: tb/tb_dbgm_matcher.sv
module tb_dbgm_matcher;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] bp_hit = '0, wp_hit = '0;
  logic [1:0] cur_el = '0;
  logic sec_state = 1'b0, wp_unpriv = 1'b0;
  logic [31:0] ctx_id = '0;
  logic mon_en = 1'b1, dbg_allow = 1'b1;
  logic bp_match, wp_match;

  int n_run = 0;
  int n_fail = 0;

  typedef struct { bit bp; bit wp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  dbgm_matcher #(.N(N), .CTX_N(4)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .bp_hit(bp_hit), .wp_hit(wp_hit), .cur_el(cur_el),
    .sec_state(sec_state), .wp_unpriv(wp_unpriv), .ctx_id(ctx_id),
    .mon_en(mon_en), .dbg_allow(dbg_allow), .bp_match(bp_match),
    .wp_match(wp_match)
  );

  // pac[0] -> bit 1 (level 1), pac[1] -> bit 2 (level 0)
  function automatic logic [31:0] mkc(bit en, bit [1:0] pac, bit hmc,
                                      bit [1:0] ssc, bit [3:0] lbn, bit lnk);
    mkc = '0;
    mkc[0] = en; mkc[2:1] = pac; mkc[13] = hmc;
    mkc[15:14] = ssc; mkc[19:16] = lbn; mkc[20] = lnk;
  endfunction

  function automatic logic [31:0] mkl(bit en, bit [3:0] typ);
    mkl = '0;
    mkl[0] = en; mkl[23:20] = typ;
  endfunction

  task automatic cfg(input logic [1:0] sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    bp_hit = '0; wp_hit = '0;
    wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply(input logic [N-1:0] bh, input logic [N-1:0] wh,
                       input logic [1:0] el, input bit sec, input bit unp,
                       input logic [31:0] ctx, input bit en, input bit al,
                       input bit ebp, input bit ewp, input string tag);
    item_t it;
    @(negedge clk);
    bp_hit = bh; wp_hit = wh; cur_el = el; sec_state = sec;
    wp_unpriv = unp; ctx_id = ctx; mon_en = en; dbg_allow = al;
    it.bp = ebp; it.wp = ewp; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        #2;
        n_run++;
        if (bp_match !== it.bp || wp_match !== it.wp) begin
          n_fail++;
          $display("FAIL %s: bp=%0b wp=%0b expected bp=%0b wp=%0b",
                   it.tag, bp_match, wp_match, it.bp, it.wp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  localparam logic [31:0] CTX = 32'hCAFE_0001;

  initial begin : driver
    repeat (3) @(negedge clk);
    bp_hit = '1; wp_hit = '1; cur_el = 2'd1;
    @(negedge clk);
    n_run++;
    if (bp_match !== 1'b0 || wp_match !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: bp=%0b wp=%0b expected 0 0 in reset", bp_match, wp_match);
    end
    rst = 1'b0;
    bp_hit = '0; wp_hit = '0;

    // R1: reset cleared all slots, nothing matches
    apply('1, '1, 2'd1, 0, 0, 0, 1, 1, 0, 0, "R1 cleared after reset");

    cfg(2'd0, 0, mkc(1, 2'b11, 0, 2'd0, 0, 0));
    apply(16'h0001, 0, 2'd1, 0, 0, 0, 1, 1, 1, 0, "R2 bp0 level1");
    apply(16'h0001, 0, 2'd0, 0, 0, 0, 1, 1, 1, 0, "R5 bp0 level0");
    apply(16'h0001, 0, 2'd2, 0, 0, 0, 1, 1, 0, 0, "R5 bp0 level2 no hmc");
    apply(16'h0001, 0, 2'd2, 0, 1, 0, 1, 1, 0, 0, "R6 bp ignores unpriv");

    cfg(2'd0, 1, mkc(1, 2'b01, 1, 2'd2, 0, 0));
    apply(16'h0002, 0, 2'd0, 1, 0, 0, 1, 1, 0, 0, "R5 bp1 level0 masked");
    apply(16'h0002, 0, 2'd1, 0, 0, 0, 1, 1, 0, 0, "R4 ssc2 nonsecure");
    apply(16'h0002, 0, 2'd1, 1, 0, 0, 1, 1, 1, 0, "R4 ssc2 secure");
    apply(16'h0002, 0, 2'd3, 1, 0, 0, 1, 1, 1, 0, "R5 hmc level3");

    cfg(2'd2, 2, mkc(1, 2'b11, 0, 2'd1, 0, 0));
    cfg(2'd2, 3, mkc(1, 2'b11, 0, 2'd3, 0, 0));
    apply(0, 16'h0004, 2'd1, 1, 0, 0, 1, 1, 0, 0, "R4 ssc1 secure");
    apply(0, 16'h0004, 2'd1, 0, 0, 0, 1, 1, 0, 1, "R4 ssc1 nonsecure");
    apply(0, 16'h0008, 2'd1, 1, 0, 0, 1, 1, 0, 0, "R4 ssc3 secure");
    apply(0, 16'h0008, 2'd0, 0, 0, 0, 1, 1, 0, 1, "R4 ssc3 nonsecure");

    cfg(2'd2, 4, mkc(1, 2'b01, 0, 2'd0, 0, 0));
    cfg(2'd2, 5, mkc(1, 2'b10, 0, 2'd0, 0, 0));
    apply(0, 16'h0010, 2'd1, 0, 0, 0, 1, 1, 0, 1, "R6 wp4 privileged");
    apply(0, 16'h0010, 2'd1, 0, 1, 0, 1, 1, 0, 0, "R6 wp4 unpriv as level0");
    apply(0, 16'h0020, 2'd1, 0, 1, 0, 1, 1, 0, 1, "R6 wp5 unpriv level1");
    apply(0, 16'h0020, 2'd2, 0, 1, 0, 1, 1, 0, 1, "R6 wp5 unpriv level2");

    cfg(2'd0, 6, mkc(0, 2'b11, 1, 2'd0, 0, 0));
    apply(16'h0040, 0, 2'd1, 0, 0, 0, 1, 1, 0, 0, "R3 disabled slot");
    apply(16'h0041, 16'h0030, 2'd1, 0, 0, 0, 1, 1, 1, 1, "R2 OR of slots");

    cfg(2'd0, 13, mkl(1, 4'd3));  cfg(2'd1, 13, CTX);
    cfg(2'd0, 10, mkl(1, 4'd3));  cfg(2'd1, 10, CTX);
    cfg(2'd0, 14, mkl(1, 4'd1));  cfg(2'd1, 14, CTX);
    cfg(2'd0, 15, mkl(0, 4'd3));  cfg(2'd1, 15, CTX);
    cfg(2'd2, 7,  mkc(1, 2'b11, 1, 2'd0, 4'd13, 1));
    cfg(2'd2, 8,  mkc(1, 2'b11, 1, 2'd0, 4'd10, 1));
    cfg(2'd2, 9,  mkc(1, 2'b11, 1, 2'd0, 4'd14, 1));
    cfg(2'd2, 10, mkc(1, 2'b11, 1, 2'd0, 4'd15, 1));
    apply(0, 16'h0080, 2'd1, 0, 0, CTX, 1, 1, 0, 1, "R8 linked ctx match");
    apply(0, 16'h0080, 2'd1, 0, 0, CTX ^ 32'h1, 1, 1, 0, 0, "R8 ctx mismatch");
    apply(0, 16'h0080, 2'd2, 0, 0, CTX, 1, 1, 0, 0, "R8 level above 1");
    apply(0, 16'h0100, 2'd1, 0, 0, CTX, 1, 1, 0, 0, "R7 link below range");
    apply(0, 16'h0200, 2'd1, 0, 0, CTX, 1, 1, 0, 0, "R8 wrong type");
    apply(0, 16'h0400, 2'd1, 0, 0, CTX, 1, 1, 0, 0, "R8 target disabled");

    apply(16'h0001, 16'h0004, 2'd1, 0, 0, 0, 0, 1, 0, 0, "R9 monitor disabled");
    apply(16'h0001, 16'h0004, 2'd1, 0, 0, 0, 1, 0, 0, 0, "R9 debug not allowed");
    apply(16'h0001, 16'h0004, 2'd1, 0, 0, 0, 1, 1, 1, 1, "R9 reenabled");

    cfg(2'd0, 0, mkc(0, 2'b11, 0, 2'd0, 0, 0));
    apply(16'h0001, 0, 2'd1, 0, 0, 0, 1, 1, 0, 0, "R1 rewrite disables bp0");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule